// File: doc/BRIEF.md
# Ethernet Receive Frame Length Checker

This block sits beside a MAC receive datapath and watches each incoming frame as a byte stream. Three strobes mark the stream: a frame-start strobe on the first byte, a byte-valid strobe on every byte, and a frame-end strobe on the last byte. The block counts every byte from the first destination-address byte through the last CRC byte. It compares the running count with a programmable ceiling. The first time a frame goes past the ceiling, it fires a one-cycle oversize interrupt. When the frame closes, it reports a "too long" status flag.

An optional check compares the payload length with the frame's length/type field. That field is read from bytes 13 and 14 of the frame. When the field holds a length and the payload does not match it, the block sets a payload-length error flag and pulses a second interrupt.

Configuration is written through a small register-style port. Each frame works from a snapshot of the configuration taken at its first byte. A write made in the middle of a frame therefore applies from the next frame on.

Top module: `rx_len_guard`

## Requirements
- R1: After reset, `irq_oversize`, `irq_plen_err`, `st_valid`, `st_too_long` and `st_plen_err` are all 0.
- R2: The ceiling register resets to 1518 and the payload-check enable resets to 0. A cycle with `cfg_we`=1 loads both `cfg_max_len` and `cfg_plen_en`.
- R3: The frame length L counts every valid byte from the frame-start byte through the frame-end byte, inclusive. `st_too_long` is 1 exactly when L is greater than the ceiling, so L equal to the ceiling is not flagged.
- R4: `irq_oversize` is high for exactly one cycle per oversize frame. It rises in the cycle after the byte that brings the count to ceiling+1.
- R5: `st_valid`, `st_too_long` and `st_plen_err` take their frame values in the cycle after the frame-end byte. They hold those values until the next frame-start byte. In the cycle after that byte they read 0, unless that byte is also a frame-end byte.
- R6: The ceiling and the enable are sampled on the frame-start byte. A write during a frame does not change that frame's result, but it does apply to the next frame.
- R7: With the check enabled, the length/type field is byte 13 (high) and byte 14 (low) of the frame. A field value of 1500 or less is a length. The expected payload is the field value, or 46 if the field is below 46. `st_plen_err` is set when L−18 differs from the expected payload. `irq_plen_err` pulses for one cycle, at the same time as the status.
- R8: No payload-length error is reported when the check is disabled, when the field exceeds 1500 (it is a type), or when the frame is shorter than 14 bytes.
- R9: The length counter saturates at 65535 and never wraps. A frame longer than 65535 bytes still gives one oversize pulse and `st_too_long`=1.
- R10: With the ceiling set to 1522, a 1522-byte frame (one carrying a 4-byte VLAN tag) passes without being flagged, and a 1523-byte frame is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Byte valid |
| rx_sof | input | 1 | First byte of frame (with rx_vld) |
| rx_eof | input | 1 | Last byte of frame (with rx_vld) |
| rx_data | input | 8 | Received byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_max_len | input | 14 | Ceiling value to write |
| cfg_plen_en | input | 1 | Payload check enable to write |
| irq_oversize | output | 1 | One-cycle oversize pulse |
| irq_plen_err | output | 1 | One-cycle payload-length error pulse |
| st_valid | output | 1 | End-of-frame status is present |
| st_too_long | output | 1 | Last frame exceeded the ceiling |
| st_plen_err | output | 1 | Last frame had a payload-length mismatch |

## Verification
The assertions assume well-formed framing. Every frame opens with a byte carrying both `rx_sof` and `rx_vld`. It closes with a byte carrying both `rx_eof` and `rx_vld`. No second frame-start arrives before the frame-end. The stimulus drives each frame as an unbroken run of valid bytes that starts and ends with those strobes, then leaves idle cycles before the next frame. Configuration writes are issued either between frames or in the middle of a frame, never on a frame-start byte.

// File: rtl/rxlg_pkg.sv
package rxlg_pkg;

    localparam int unsigned LEN_W      = 16;
    localparam int unsigned MAX_W      = 14;
    localparam int unsigned HDR_CRC    = 18;
    localparam int unsigned MIN_PAY    = 46;
    localparam int unsigned LT_LEN_TOP = 1500;
    localparam int unsigned LT_HI_POS  = 13;
    localparam int unsigned LT_LO_POS  = 14;
    localparam int unsigned DEF_MAX    = 1518;

    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        logic [MAX_W-1:0] max_len;
        logic             plen_en;
    } frame_cfg_t;

    typedef struct packed {
        logic done;
        logic too_long;
        logic plen_err;
    } eof_stat_t;

    function automatic len_t sat_inc(input len_t v);
        return (v == '1) ? v : v + len_t'(1);
    endfunction

    function automatic logic lt_is_len(input logic [15:0] lt);
        return lt <= 16'(LT_LEN_TOP);
    endfunction

    function automatic logic plen_bad(input len_t len, input logic [15:0] lt);
        logic [15:0] want;
        want = (lt < 16'(MIN_PAY)) ? 16'(MIN_PAY) : lt;
        if (len < len_t'(HDR_CRC)) return 1'b1;
        return (16'(len - len_t'(HDR_CRC))) != want;
    endfunction

endpackage

// File: rtl/rxlg_cfg_regs.sv
module rxlg_cfg_regs
    import rxlg_pkg::*;
#(
    parameter int unsigned MAX_RESET     = DEF_MAX,
    parameter bit          PLEN_EN_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [MAX_W-1:0] wmax,
    input  logic             wen,
    input  logic             sof_take,
    output frame_cfg_t       act_cfg
);
    frame_cfg_t reg_q;
    frame_cfg_t snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q.max_len <= MAX_W'(MAX_RESET);
            reg_q.plen_en <= PLEN_EN_RESET;
        end else if (we) begin
            reg_q.max_len <= wmax;
            reg_q.plen_en <= wen;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q.max_len <= MAX_W'(MAX_RESET);
            snap_q.plen_en <= PLEN_EN_RESET;
        end else if (sof_take) begin
            snap_q <= reg_q;
        end
    end

    assign act_cfg = sof_take ? reg_q : snap_q;
endmodule

// File: rtl/rxlg_len_counter.sv
module rxlg_len_counter
    import rxlg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic             sof,
    input  logic             eof,
    input  logic [MAX_W-1:0] max_len,
    output logic             take,
    output len_t             nxt_len,
    output len_t             cnt_q,
    output logic             frame_over,
    output logic             irq_q
);
    logic in_frame_q;
    logic seen_q;
    logic over_now;
    logic first_over;

    assign take       = vld && (sof || in_frame_q);
    assign nxt_len    = sof ? len_t'(1) : sat_inc(cnt_q);
    assign over_now   = take && (nxt_len > len_t'(max_len));
    assign first_over = over_now && (sof || !seen_q);
    assign frame_over = over_now || (seen_q && !sof);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            in_frame_q <= 1'b0;
            seen_q     <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= first_over;
            if (take) begin
                cnt_q      <= nxt_len;
                in_frame_q <= !eof;
                seen_q     <= frame_over;
            end
        end
    end
endmodule

// File: rtl/rxlg_lt_capture.sv
module rxlg_lt_capture
    import rxlg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        sof,
    input  len_t        nxt_len,
    input  logic [7:0]  data,
    output logic [15:0] lt_now,
    output logic        lt_have
);
    logic [7:0]  hi_q;
    logic [15:0] lt_q;
    logic        have_q;
    logic        at_hi;
    logic        at_lo;

    assign at_hi   = take && (nxt_len == len_t'(LT_HI_POS));
    assign at_lo   = take && (nxt_len == len_t'(LT_LO_POS));
    assign lt_now  = at_lo ? {hi_q, data} : lt_q;
    assign lt_have = at_lo || (have_q && !sof);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lt_q   <= '0;
            have_q <= 1'b0;
        end else begin
            if (at_hi) hi_q <= data;
            if (at_lo) lt_q <= {hi_q, data};
            if (take) have_q <= lt_have;
        end
    end
endmodule

// File: rtl/rxlg_status.sv
module rxlg_status
    import rxlg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        sof,
    input  logic        eof,
    input  logic        frame_over,
    input  logic        plen_en,
    input  logic        lt_have,
    input  logic [15:0] lt_now,
    input  len_t        nxt_len,
    output eof_stat_t   stat_q,
    output logic        irq_plen_q
);
    logic      err;
    eof_stat_t stat_d;

    assign err = plen_en && lt_have && lt_is_len(lt_now) && plen_bad(nxt_len, lt_now);

    always_comb begin
        stat_d.done     = 1'b1;
        stat_d.too_long = frame_over;
        stat_d.plen_err = err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q     <= '0;
            irq_plen_q <= 1'b0;
        end else begin
            irq_plen_q <= take && eof && err;
            if (take && eof)      stat_q <= stat_d;
            else if (take && sof) stat_q <= '0;
        end
    end
endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard
    import rxlg_pkg::*;
#(
    parameter int unsigned MAX_RESET     = DEF_MAX,
    parameter bit          PLEN_EN_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_vld,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             cfg_we,
    input  logic [MAX_W-1:0] cfg_max_len,
    input  logic             cfg_plen_en,
    output logic             irq_oversize,
    output logic             irq_plen_err,
    output logic             st_valid,
    output logic             st_too_long,
    output logic             st_plen_err
);
    frame_cfg_t  act_cfg;
    logic        take;
    len_t        nxt_len;
    len_t        frm_cnt;
    logic        frame_over;
    logic [15:0] lt_now;
    logic        lt_have;
    eof_stat_t   stat;

    rxlg_cfg_regs #(.MAX_RESET(MAX_RESET), .PLEN_EN_RESET(PLEN_EN_RESET)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wmax(cfg_max_len), .wen(cfg_plen_en),
        .sof_take(rx_vld && rx_sof), .act_cfg(act_cfg)
    );

    rxlg_len_counter u_cnt (
        .clk(clk), .rst(rst), .vld(rx_vld), .sof(rx_sof), .eof(rx_eof),
        .max_len(act_cfg.max_len), .take(take), .nxt_len(nxt_len), .cnt_q(frm_cnt),
        .frame_over(frame_over), .irq_q(irq_oversize)
    );

    rxlg_lt_capture u_lt (
        .clk(clk), .rst(rst), .take(take), .sof(rx_sof), .nxt_len(nxt_len),
        .data(rx_data), .lt_now(lt_now), .lt_have(lt_have)
    );

    rxlg_status u_st (
        .clk(clk), .rst(rst), .take(take), .sof(rx_sof), .eof(rx_eof),
        .frame_over(frame_over), .plen_en(act_cfg.plen_en), .lt_have(lt_have),
        .lt_now(lt_now), .nxt_len(nxt_len), .stat_q(stat), .irq_plen_q(irq_plen_err)
    );

    assign st_valid    = stat.done;
    assign st_too_long = stat.too_long;
    assign st_plen_err = stat.plen_err;
endmodule

// File: rtl/rxlg_chk.sv
module rxlg_chk
    import rxlg_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic rx_vld,
    input logic rx_sof,
    input logic rx_eof,
    input logic irq_oversize,
    input logic irq_plen_err,
    input logic st_valid,
    input logic st_too_long,
    input logic st_plen_err,
    input len_t cnt
);
    // R4
    oversize_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_oversize |=> !irq_oversize);

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !(rx_vld && (rx_sof || rx_eof))) |=>
            (st_valid && $stable(st_too_long) && $stable(st_plen_err)));

    // R5
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && rx_sof && !rx_eof) |=> !st_valid);

    // R7
    plen_irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq_plen_err |-> (st_valid && st_plen_err));

    // R3
    too_long_valid_chk: assert property (@(posedge clk) disable iff (rst)
        st_too_long |-> st_valid);

    // R9
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1 && !(rx_vld && rx_sof)) |=> cnt == '1);
endmodule

bind rx_len_guard rxlg_chk u_chk (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .irq_oversize(irq_oversize), .irq_plen_err(irq_plen_err), .st_valid(st_valid),
    .st_too_long(st_too_long), .st_plen_err(st_plen_err), .cnt(frm_cnt)
);

// File: tb/rx_len_guard_bench.sv
module rx_len_guard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_vld = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cfg_we = 1'b0, cfg_plen_en = 1'b0;
    logic [13:0] cfg_max_len = '0;
    logic        irq_oversize, irq_plen_err, st_valid, st_too_long, st_plen_err;

    int n_chk = 0;
    int n_bad = 0;
    int m_max = 1518;
    bit m_en  = 1'b0;

    always #5 clk = ~clk;

    rx_len_guard u_rx_len_guard (
        .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_data(rx_data), .cfg_we(cfg_we), .cfg_max_len(cfg_max_len),
        .cfg_plen_en(cfg_plen_en), .irq_oversize(irq_oversize),
        .irq_plen_err(irq_plen_err), .st_valid(st_valid),
        .st_too_long(st_too_long), .st_plen_err(st_plen_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_plen(input int len, input int lt, input bit en);
        int want;
        if (!en || len < 14 || lt > 1500) return 1'b0;
        want = (lt < 46) ? 46 : lt;
        return (len - 18) != want;
    endfunction

    task automatic wr_cfg(input int mx, input bit en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_max_len = 14'(mx); cfg_plen_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        m_max = mx; m_en = en;
    endtask

    // Sends one frame and checks its pulses and status; wr_at>0 writes config mid-frame.
    task automatic send_frame(input string tag, input int len, input int lt,
                              input int wr_at, input int wmax, input bit wen);
        int  f_max = m_max;
        bit  f_en  = m_en;
        int  pulses = 0;
        int  trig = 0;
        bit  exp_long;
        bit  exp_err;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (i > 1 && irq_oversize) begin pulses++; trig = i - 1; end
            if (i == 2) check({tag, " R5 cleared after frame start"}, int'(st_valid), 0);
            rx_vld = 1'b1;
            rx_sof = (i == 1);
            rx_eof = (i == len);
            rx_data = (i == 13) ? 8'(lt >> 8) : (i == 14) ? 8'(lt) : 8'(i);
            if (i == wr_at) begin
                cfg_we = 1'b1; cfg_max_len = 14'(wmax); cfg_plen_en = wen;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        if (wr_at > 0) begin m_max = wmax; m_en = wen; end
        if (irq_oversize) begin pulses++; trig = len; end
        rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        exp_long = (len > f_max);
        exp_err  = exp_plen(len, lt, f_en);
        check({tag, " R5 status valid"}, int'(st_valid), 1);
        check({tag, " R3 too long"}, int'(st_too_long), int'(exp_long));
        check({tag, " R7 plen err"}, int'(st_plen_err), int'(exp_err));
        check({tag, " R7 plen irq"}, int'(irq_plen_err), int'(exp_err));
        check({tag, " R4 oversize pulses"}, pulses, exp_long ? 1 : 0);
        if (exp_long) check({tag, " R4 pulse position"}, trig, f_max + 1);
        @(negedge clk);
        check({tag, " R5 status held"}, int'(st_valid), 1);
        check({tag, " R5 too long held"}, int'(st_too_long), int'(exp_long));
        check({tag, " R7 plen irq one cycle"}, int'(irq_plen_err), 0);
        check({tag, " R4 no late pulse"}, int'(irq_oversize), 0);
    endtask

    task automatic t_reset;
        check("R1 irq_oversize", int'(irq_oversize), 0);
        check("R1 irq_plen_err", int'(irq_plen_err), 0);
        check("R1 st_valid", int'(st_valid), 0);
        check("R1 st_too_long", int'(st_too_long), 0);
        check("R1 st_plen_err", int'(st_plen_err), 0);
    endtask

    task automatic t_default_ceiling;
        // R2: reset ceiling 1518 and enable off; R3 boundary
        send_frame("R2 len1518", 1518, 16'h0800, 0, 0, 0);
        send_frame("R2 len1519", 1519, 100, 0, 0, 0);
        send_frame("R3 single byte", 1, 0, 0, 0, 0);
    endtask

    task automatic t_vlan;
        // R10
        wr_cfg(1522, 1'b0);
        send_frame("R10 len1522", 1522, 16'h8100, 0, 0, 0);
        send_frame("R10 len1523", 1523, 16'h8100, 0, 0, 0);
    endtask

    task automatic t_small_ceiling;
        wr_cfg(64, 1'b0);
        send_frame("R4 len200", 200, 16'h0800, 0, 0, 0);
        send_frame("R3 len64", 64, 16'h0800, 0, 0, 0);
        send_frame("R3 len65", 65, 16'h0800, 0, 0, 0);
    endtask

    task automatic t_payload;
        wr_cfg(1518, 1'b1);
        send_frame("R7 exact", 118, 100, 0, 0, 0);
        send_frame("R7 mismatch", 119, 100, 0, 0, 0);
        send_frame("R7 padded ok", 64, 20, 0, 0, 0);
        send_frame("R7 padded bad", 70, 20, 0, 0, 0);
        send_frame("R7 field1500", 1518, 1500, 0, 0, 0);
        send_frame("R8 type field", 70, 16'h0800, 0, 0, 0);
        send_frame("R8 short frame", 10, 0, 0, 0, 0);
        wr_cfg(1518, 1'b0);
        send_frame("R8 disabled", 119, 100, 0, 0, 0);
    endtask

    task automatic t_midframe;
        // R6: write during the frame applies only to the next one
        wr_cfg(1518, 1'b1);
        send_frame("R6 in-flight", 100, 50, 10, 64, 1'b0);
        send_frame("R6 next frame", 100, 50, 0, 0, 0);
    endtask

    task automatic t_saturate;
        // R9
        wr_cfg(1518, 1'b0);
        send_frame("R9 saturate", 65636, 16'h0800, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_ceiling();
        t_vlan();
        t_small_ceiling();
        t_payload();
        t_midframe();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule